// File: doc/BRIEF.md
# Boost PFC Cycle Protection Sequencer

This block sequences the gate drive of a critical-conduction boost converter, one switching cycle at a time. An on-time begins on a start request, on a rising zero-current-detect edge, or after a watchdog restart. It ends when the external on-time timer reports done or when the over-current comparator trips. The over-current comparator is ignored for a blanking window after turn-on, so switching spikes cannot end the cycle.

An over-stress comparator is watched during the whole on-time, from its first clock. A high level shuts the gate at once and holds it off for a long lockout. If no demagnetization edge arrives after turn-off, a watchdog expires. The block then asks for a pin-impedance check through a request/grant handshake. A healthy pin restarts switching. A grounded pin latches a fault that only reset clears.

Every interval is set in nanoseconds or microseconds and turned into clock ticks from a single clock-frequency parameter. Outputs are registered: the gate and the status lines change one clock after the input that causes them.

Top module: `pfc_cycle_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, gate_en, pin_req, ocp_evt, ovs_lock, wdog_evt and pin_fault are all 0, and the block waits idle.
- R2: In the idle state, start_req high starts an on-time: gate_en is 1 from the next clock. A ton_done high during an on-time drops gate_en at the next clock. The block then waits for a demagnetization edge.
- R3: During the first BLANK_TICKS clocks of an on-time (BLANK_TICKS = CLK_HZ*BLANK_NS/1e9, 25 at 125 MHz and 200 ns), ocp_trip has no effect on gate_en.
- R4: After the blanking window, ocp_trip high during an on-time drops gate_en at the next clock. In that same clock, ocp_evt is high for exactly one clock.
- R5: ovs_trip high in any on-time clock, including the first, drops gate_en at the next clock. ovs_lock is then 1 for exactly LOCK_TICKS clocks (CLK_HZ*LOCK_US/1e6). After that the block returns to idle.
- R6: While waiting after turn-off, a 0-to-1 change of zcd_in starts a new on-time from the next clock. zcd_in that stays high without a new rising edge starts nothing.
- R7: If no rising zcd_in edge arrives within WDOG_TICKS clocks of turn-off (CLK_HZ*WDOG_US/1e6), pin_req rises and stays high until pin_gnt. A grant with pin_grounded low starts an on-time, and wdog_evt is high for one clock with gate_en.
- R8: A grant with pin_grounded high sets pin_fault. pin_fault stays 1 and gate_en stays 0 until reset, whatever start_req, zcd_in or the comparators do.
- R9: During the over-stress lockout, start_req and rising zcd_in edges do not raise gate_en.
- R10: When several terminations arrive in the same on-time clock, ovs_trip wins over ocp_trip, and ocp_trip wins over ton_done. At most one of gate_en, ovs_lock, pin_req and pin_fault is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Cycle-start request, honoured only when idle |
| ocp_trip | input | 1 | Over-current comparator output |
| ovs_trip | input | 1 | Over-stress comparator output |
| zcd_in | input | 1 | Zero-current-detect comparator output |
| ton_done | input | 1 | External on-time timer finished |
| pin_gnt | input | 1 | Pin-impedance check result valid |
| pin_grounded | input | 1 | Pin found grounded, valid with pin_gnt |
| gate_en | output | 1 | Gate drive enable (PWM latch state) |
| pin_req | output | 1 | Request for a pin-impedance check |
| ocp_evt | output | 1 | One-clock pulse: on-time ended by over-current |
| ovs_lock | output | 1 | Over-stress lockout in progress |
| wdog_evt | output | 1 | One-clock pulse: on-time started by watchdog |
| pin_fault | output | 1 | Latched grounded-pin fault |

## Verification
The lockout and the watchdog are hard to reach from the ports in reasonable time. Their default lengths are tens of millions of clocks, so the bench shortens them through the microsecond parameters while keeping the real 200 ns blanking. The hardest case is an over-stress trip in the very first on-time clock. Here the over-stress input must be raised together with the zero-current edge while the block waits after turn-off, and held across two edges, so that it is seen exactly at turn-on. Same-clock collisions of over-stress, over-current and on-time done are driven on purpose to settle the priority. The grounded-pin path is reached only after a real watchdog expiry and a delayed grant.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ON    = 3'd1,
    ST_OFF   = 3'd2,
    ST_PIN   = 3'd3,
    ST_LOCK  = 3'd4,
    ST_FAULT = 3'd5
  } seq_state_t;

  // ticks = hz * amount / unit_per_second
  function automatic int to_ticks(longint hz, longint amount, longint per_sec);
    return int'((hz * amount) / per_sec);
  endfunction

endpackage

// File: rtl/pfc_rise_det.sv
module pfc_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise
);
  logic d_q;

  always_ff @(posedge clk) begin
    if (rst) d_q <= 1'b1;
    else     d_q <= d;
  end

  assign rise = d & ~d_q;
endmodule

// File: rtl/pfc_elapsed_cnt.sv
module pfc_elapsed_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)     count <= '0;
    else if (count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/pfc_seq_ctrl.sv
module pfc_seq_ctrl
  import pfc_seq_pkg::*;
#(
  parameter int CW = 8,
  parameter int BT = 25,
  parameter int LT = 100,
  parameter int WT = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic          ocp_trip,
  input  logic          ovs_trip,
  input  logic          zcd_rise,
  input  logic          ton_done,
  input  logic          pin_gnt,
  input  logic          pin_grounded,
  input  logic [CW-1:0] count,
  output logic          cnt_clr,
  output logic          gate_en,
  output logic          pin_req,
  output logic          ocp_evt,
  output logic          ovs_lock,
  output logic          wdog_evt,
  output logic          pin_fault
);
  localparam logic [CW-1:0] BLANK_END = CW'(BT);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LT - 1);
  localparam logic [CW-1:0] WDOG_LAST = CW'(WT - 1);

  seq_state_t st, st_n;
  logic       ocp_p, wd_p;

  always_comb begin
    st_n  = st;
    ocp_p = 1'b0;
    wd_p  = 1'b0;
    unique case (st)
      ST_IDLE: if (start_req) st_n = ST_ON;
      ST_ON: begin
        if (ovs_trip) st_n = ST_LOCK;
        else if (ocp_trip && count >= BLANK_END) begin
          st_n  = ST_OFF;
          ocp_p = 1'b1;
        end
        else if (ton_done) st_n = ST_OFF;
      end
      ST_OFF: begin
        if (zcd_rise)               st_n = ST_ON;
        else if (count == WDOG_LAST) st_n = ST_PIN;
      end
      ST_PIN: begin
        if (pin_gnt) begin
          st_n = pin_grounded ? ST_FAULT : ST_ON;
          wd_p = ~pin_grounded;
        end
      end
      ST_LOCK:  if (count == LOCK_LAST) st_n = ST_IDLE;
      ST_FAULT: st_n = ST_FAULT;
      default:  st_n = ST_IDLE;
    endcase
  end

  assign cnt_clr = (st_n != st);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      gate_en   <= 1'b0;
      pin_req   <= 1'b0;
      ocp_evt   <= 1'b0;
      ovs_lock  <= 1'b0;
      wdog_evt  <= 1'b0;
      pin_fault <= 1'b0;
    end else begin
      st        <= st_n;
      gate_en   <= (st_n == ST_ON);
      pin_req   <= (st_n == ST_PIN);
      ovs_lock  <= (st_n == ST_LOCK);
      pin_fault <= (st_n == ST_FAULT);
      ocp_evt   <= ocp_p;
      wdog_evt  <= wd_p;
    end
  end
endmodule

// File: rtl/pfc_cycle_seq.sv
module pfc_cycle_seq
  import pfc_seq_pkg::*;
#(
  parameter int CLK_HZ   = 125_000_000,
  parameter int BLANK_NS = 200,
  parameter int LOCK_US  = 800_000,
  parameter int WDOG_US  = 200_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic ocp_trip,
  input  logic ovs_trip,
  input  logic zcd_in,
  input  logic ton_done,
  input  logic pin_gnt,
  input  logic pin_grounded,
  output logic gate_en,
  output logic pin_req,
  output logic ocp_evt,
  output logic ovs_lock,
  output logic wdog_evt,
  output logic pin_fault
);
  localparam int BLANK_TICKS = to_ticks(CLK_HZ, BLANK_NS, 64'd1_000_000_000);
  localparam int LOCK_TICKS  = to_ticks(CLK_HZ, LOCK_US, 64'd1_000_000);
  localparam int WDOG_TICKS  = to_ticks(CLK_HZ, WDOG_US, 64'd1_000_000);
  localparam int MAX_A = (BLANK_TICKS > LOCK_TICKS) ? BLANK_TICKS : LOCK_TICKS;
  localparam int MAX_T = (MAX_A > WDOG_TICKS) ? MAX_A : WDOG_TICKS;
  localparam int CW    = $clog2(MAX_T + 2);

  logic          zcd_rise;
  logic          cnt_clr;
  logic [CW-1:0] count;

  pfc_rise_det u_zcd (
    .clk (clk),
    .rst (rst),
    .d   (zcd_in),
    .rise(zcd_rise)
  );

  pfc_elapsed_cnt #(.W(CW)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .count(count)
  );

  pfc_seq_ctrl #(
    .CW(CW), .BT(BLANK_TICKS), .LT(LOCK_TICKS), .WT(WDOG_TICKS)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_req   (start_req),
    .ocp_trip    (ocp_trip),
    .ovs_trip    (ovs_trip),
    .zcd_rise    (zcd_rise),
    .ton_done    (ton_done),
    .pin_gnt     (pin_gnt),
    .pin_grounded(pin_grounded),
    .count       (count),
    .cnt_clr     (cnt_clr),
    .gate_en     (gate_en),
    .pin_req     (pin_req),
    .ocp_evt     (ocp_evt),
    .ovs_lock    (ovs_lock),
    .wdog_evt    (wdog_evt),
    .pin_fault   (pin_fault)
  );
endmodule

// File: rtl/pfc_cycle_seq_chk.sv
module pfc_cycle_seq_chk #(
  parameter int CLK_HZ   = 125_000_000,
  parameter int BLANK_NS = 200
) (
  input logic clk,
  input logic rst,
  input logic pin_gnt,
  input logic pin_grounded,
  input logic gate_en,
  input logic pin_req,
  input logic ocp_evt,
  input logic ovs_lock,
  input logic wdog_evt,
  input logic pin_fault
);
  localparam int BT = pfc_seq_pkg::to_ticks(CLK_HZ, BLANK_NS, 64'd1_000_000_000);

  int on_len;
  always_ff @(posedge clk) begin
    if (rst)          on_len <= 0;
    else if (gate_en) on_len <= on_len + 1;
    else              on_len <= 0;
  end

  p_blank_r3: assert property (@(posedge clk) disable iff (rst)
    ocp_evt |-> (on_len > BT));
  p_ocp_cut_r4: assert property (@(posedge clk) disable iff (rst)
    ocp_evt |-> (!gate_en && $past(gate_en)));
  p_lock_gate_off_r5: assert property (@(posedge clk) disable iff (rst)
    ovs_lock |-> !gate_en);
  p_lock_entry_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovs_lock) |-> $past(gate_en));
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (pin_req && !pin_gnt) |=> pin_req);
  p_wd_start_r7: assert property (@(posedge clk) disable iff (rst)
    wdog_evt |-> (gate_en && $past(pin_req)));
  p_gnd_fault_r8: assert property (@(posedge clk) disable iff (rst)
    (pin_req && pin_gnt && pin_grounded) |=> pin_fault);
  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    pin_fault |=> (pin_fault && !gate_en));
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gate_en, ovs_lock, pin_req, pin_fault}));
endmodule

bind pfc_cycle_seq pfc_cycle_seq_chk #(.CLK_HZ(CLK_HZ), .BLANK_NS(BLANK_NS)) u_chk (
  .clk(clk), .rst(rst), .pin_gnt(pin_gnt), .pin_grounded(pin_grounded),
  .gate_en(gate_en), .pin_req(pin_req), .ocp_evt(ocp_evt), .ovs_lock(ovs_lock),
  .wdog_evt(wdog_evt), .pin_fault(pin_fault)
);

// File: tb/tb_pfc_cycle_seq.sv
`timescale 1ns/1ps
module tb_pfc_cycle_seq;
  localparam int CLK_HZ   = 125_000_000;
  localparam int BLANK_NS = 200;
  localparam int LOCK_US  = 8;
  localparam int WDOG_US  = 2;
  localparam int BT = 25;
  localparam int LT = 1000;
  localparam int WT = 250;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 0, ocp_trip = 0, ovs_trip = 0, zcd_in = 0, ton_done = 0;
  logic pin_gnt = 0, pin_grounded = 0;
  logic gate_en, pin_req, ocp_evt, ovs_lock, wdog_evt, pin_fault;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pfc_cycle_seq #(.CLK_HZ(CLK_HZ), .BLANK_NS(BLANK_NS), .LOCK_US(LOCK_US),
                  .WDOG_US(WDOG_US)) dut (
    .clk(clk), .rst(rst), .start_req(start_req), .ocp_trip(ocp_trip),
    .ovs_trip(ovs_trip), .zcd_in(zcd_in), .ton_done(ton_done),
    .pin_gnt(pin_gnt), .pin_grounded(pin_grounded), .gate_en(gate_en),
    .pin_req(pin_req), .ocp_evt(ocp_evt), .ovs_lock(ovs_lock),
    .wdog_evt(wdog_evt), .pin_fault(pin_fault));

  // Behavioural reference: phase numbers, elapsed / remaining timers
  int phase = 0;       // 0 idle 1 on 2 off 3 pin 4 lock 5 fault
  int on_age = 0, wd_left = 0, lock_left = 0;
  bit z_prev = 1;
  bit m_ocp = 0, m_wd = 0;

  always @(posedge clk) begin
    bit rise;
    rise = zcd_in && !z_prev;
    z_prev = zcd_in;
    m_ocp = 0;
    m_wd = 0;
    if (rst) begin
      phase = 0; z_prev = 1;
    end else begin
      case (phase)
        0: if (start_req) begin phase = 1; on_age = 0; end
        1: begin
          if (ovs_trip) begin phase = 4; lock_left = LT; end
          else if (ocp_trip && on_age >= BT) begin phase = 2; wd_left = WT; m_ocp = 1; end
          else if (ton_done) begin phase = 2; wd_left = WT; end
          else on_age++;
        end
        2: begin
          if (rise) begin phase = 1; on_age = 0; end
          else begin wd_left--; if (wd_left == 0) phase = 3; end
        end
        3: if (pin_gnt) begin
          if (pin_grounded) phase = 5;
          else begin phase = 1; on_age = 0; m_wd = 1; end
        end
        4: begin lock_left--; if (lock_left == 0) phase = 0; end
        default: phase = 5;
      endcase
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("R2 model gate_en",  gate_en,   phase == 1);
      chk("R4 model ocp_evt",  ocp_evt,   m_ocp);
      chk("R5 model ovs_lock", ovs_lock,  phase == 4);
      chk("R7 model pin_req",  pin_req,   phase == 3);
      chk("R7 model wdog_evt", wdog_evt,  m_wd);
      chk("R8 model pin_fault", pin_fault, phase == 5);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic zcd_edge();
    zcd_in = 0; step(1); zcd_in = 1; step(1); zcd_in = 0;
  endtask

  task automatic end_on();
    ton_done = 1; step(1); ton_done = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog timeout actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 reset gate_en", gate_en, 0);
    chk("R1 reset pin_fault", pin_fault, 0);
    rst = 0;
    step(1);
    chk("R1 after reset ovs_lock", ovs_lock, 0);
    chk("R1 after reset pin_req", pin_req, 0);

    // R2: start then on-time done
    start_req = 1; step(1); start_req = 0;
    chk("R2 gate after start", gate_en, 1);
    step(10); end_on();
    chk("R2 gate off after ton_done", gate_en, 0);

    // R6: zcd edge restarts; held-high zcd does not
    zcd_edge();
    chk("R6 gate after zcd edge", gate_en, 1);
    step(5);
    zcd_in = 1; end_on();
    step(40);
    chk("R6 held zcd no restart", gate_en, 0);
    zcd_in = 0; step(1);

    // R3/R4: blanking then over-current
    zcd_in = 1; ocp_trip = 1;
    step(26);
    chk("R3 gate kept during blanking", gate_en, 1);
    step(1);
    chk("R4 gate cut by ocp", gate_en, 0);
    chk("R4 ocp_evt pulse", ocp_evt, 1);
    ocp_trip = 0; zcd_in = 0;
    step(1);
    chk("R4 ocp_evt single clock", ocp_evt, 0);

    // R10: ocp and ton_done together
    zcd_edge(); step(30);
    ocp_trip = 1; ton_done = 1; step(1);
    ocp_trip = 0; ton_done = 0;
    chk("R10 ocp wins over ton_done", ocp_evt, 1);

    // R7: watchdog, delayed grant, pin healthy
    while (!pin_req) step(1);
    step(5);
    chk("R7 pin_req held until grant", pin_req, 1);
    pin_gnt = 1; step(1); pin_gnt = 0;
    chk("R7 watchdog restart gate", gate_en, 1);
    chk("R7 wdog_evt pulse", wdog_evt, 1);
    step(3);

    // R10: ovs wins over ocp
    ovs_trip = 1; ocp_trip = 1; step(1);
    ovs_trip = 0; ocp_trip = 0;
    chk("R10 ovs wins over ocp", ovs_lock, 1);
    chk("R10 no ocp_evt on ovs", ocp_evt, 0);
    while (ovs_lock) step(1);
    start_req = 1; step(1); start_req = 0;
    end_on();

    // R5: ovs seen in first on-time clock, exact lockout length
    zcd_in = 0; step(1);
    zcd_in = 1; ovs_trip = 1;
    step(1);
    chk("R5 gate raised at turn-on", gate_en, 1);
    step(1); ovs_trip = 0; zcd_in = 0;
    chk("R5 gate cut in first on clock", gate_en, 0);
    begin
      int len;
      len = 0;
      while (ovs_lock) begin
        len++;
        if (len == 100) begin start_req = 1; zcd_in = 1; end
        if (len == 101) begin start_req = 0; zcd_in = 0; end
        if (len == 103) chk("R9 no start during lockout", gate_en, 0);
        step(1);
      end
      checks++;
      if (len != LT) begin
        errors++;
        $display("FAIL R5 lockout length actual=%0d expected=%0d", len, LT);
      end
    end

    // R8: grounded pin
    start_req = 1; step(1); start_req = 0;
    end_on();
    while (!pin_req) step(1);
    pin_grounded = 1; pin_gnt = 1; step(1); pin_gnt = 0; pin_grounded = 0;
    chk("R8 pin_fault set", pin_fault, 1);
    start_req = 1; step(2); start_req = 0;
    zcd_edge(); step(3);
    chk("R8 gate stays off in fault", gate_en, 0);
    chk("R8 pin_fault latched", pin_fault, 1);

    // R1: reset clears the fault
    rst = 1; step(2); rst = 0; step(1);
    chk("R1 fault cleared by reset", pin_fault, 0);
    chk("R1 gate low after reset", gate_en, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule